// File: doc/BRIEF.md
# SCSI Controller Host Register Interface with PIO FIFO

This block is the byte-wide host register interface of a SCSI controller core. The host addresses sixteen byte registers through a small word-aligned address. Two of them form a 16-bit transfer count. One is a data port backed by a byte FIFO, which software uses for programmed I/O. One is a command register. Some registers simply hold what was written. Others take their effect only on outputs, such as the target id field.

Writing the command register does three things. It latches bit 7 as the DMA/PIO mode flag. It emits a one-cycle dispatch strobe that carries the 7-bit command code to the sequencer of the core. In PIO mode, a transfer-information command reloads the FIFO byte count from the transfer-count registers and rewinds the buffer. Each byte the host pops from the data port raises a one-cycle interrupt pulse. When the count drains to zero, both buffer pointers return to slot 0.

Top module: `scsi_pio_regif`

## Requirements
- R1: The register index is `reg_addr[5:2]`, which gives 16 byte registers. Read data appears on `reg_rdata` in the cycle after the edge that samples `reg_rd`, and holds until the next read.
- R2: Registers 0, 1, 3, 8 and 11 to 15 read back the last byte written to them. Registers 4 to 7, 9 and 10 always read as 0x00. All of them read 0x00 after reset.
- R3: A write to register 2 stores the byte in the FIFO and raises the byte count by one. When the count is already 64 (the buffer depth), the write is dropped.
- R4: A read of register 2 with a nonzero count returns the oldest unread byte and lowers the count by one. `irq` is high for exactly the cycle after that read.
- R5: A read of register 2 with a zero count returns the value of the previous register-2 read, does not pulse `irq`, and leaves the FIFO unchanged.
- R6: When the count reaches zero, both the read and write pointers return to buffer slot 0.
- R7: A write to register 3 latches bit 7 onto `dma_mode`, which holds until the next register-3 write. In the following cycle it pulses `cmd_strobe` for one cycle, with `cmd_code` equal to bits 6:0 of the written byte.
- R8: A register-3 write of code 0x10 with bit 7 clear loads the count from {register 1, register 0} and rewinds both pointers. The same code with bit 7 set leaves the FIFO untouched.
- R9: `target_id` equals bits 2:0 of the last byte written to register 4.
- R10: When `reg_wr` and `reg_rd` are high in the same cycle, only the write takes place. `reg_rdata` holds and no byte is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register index, address bits 5:2 |
| reg_wr | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after a read |
| irq | output | 1 | One-cycle pulse per popped FIFO byte |
| dma_mode | output | 1 | Latched command bit 7 |
| cmd_strobe | output | 1 | One-cycle command dispatch pulse |
| cmd_code | output | 7 | Code of the last dispatched command |
| target_id | output | 3 | Bits 2:0 of register 4 |

## Verification
The hardest state to reach from the ports is the pointer rewind. Ordinary FIFO traffic behaves the same whether or not the pointers return to slot 0. The stimulus therefore drains the FIFO to zero and writes one new byte. It then issues a PIO transfer-information command with a count of two, which exposes buffer slots 0 and 1 directly. The new byte must come out first, followed by the stale second byte of the earlier burst. The full-buffer drop is reached by pushing all 64 slots plus one extra byte. The bench then confirms that exactly 64 pops raise `irq`.

// File: rtl/scsi_pio_pkg.sv
package scsi_pio_pkg;
  localparam int unsigned NUM_REGS = 16;
  localparam int unsigned IDX_W    = 4;

  localparam logic [IDX_W-1:0] IDX_TC_LO  = 4'd0;
  localparam logic [IDX_W-1:0] IDX_TC_HI  = 4'd1;
  localparam logic [IDX_W-1:0] IDX_FIFO   = 4'd2;
  localparam logic [IDX_W-1:0] IDX_CMD    = 4'd3;
  localparam logic [IDX_W-1:0] IDX_TARGET = 4'd4;

  // registers whose written value is visible on reads
  localparam logic [NUM_REGS-1:0] READBACK_MASK = 16'hF90B;

  localparam logic [6:0] CMD_XFER_INFO = 7'h10;
endpackage

// File: rtl/scsi_pio_fifo.sv
module scsi_pio_fifo #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_count,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_pulse
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [CNT_W-1:0]  count;
  logic              push_ok, pop_ok;

  assign push_ok = push && !load && (count < FULL_LVL);
  assign pop_ok  = pop_req && !load && (count != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      pop_pulse <= 1'b0;
    end else begin
      pop_pulse <= pop_ok;
      if (load) begin
        count <= load_count;
        wptr  <= '0;
        rptr  <= '0;
      end else if (push_ok) begin
        wptr  <= wptr + 1'b1;
        count <= count + 1'b1;
      end else if (pop_ok) begin
        count <= count - 1'b1;
        if (count == CNT_W'(1)) begin
          rptr <= '0;
          wptr <= '0;
        end else begin
          rptr <= rptr + 1'b1;
        end
      end
    end
  end

  // storage without reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         pop_data <= '0;
    else if (pop_ok) pop_data <= mem[rptr];
  end

  // R3: a push into a full buffer changes nothing
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && !load && !pop_req && count >= FULL_LVL) |=> (count == $past(count) && wptr == $past(wptr)));

  // R4: a successful pop lowers the count by one and pulses the interrupt
  a_r4_pop_decrement: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push && !load && count != '0) |=> (count == $past(count) - 1'b1 && pop_pulse));

  // R5: a pop on an empty buffer leaves the data and count alone
  a_r5_empty_hold: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push && !load && count == '0) |=> ($stable(pop_data) && count == '0 && !pop_pulse));

  // R6: an empty buffer always has both pointers at slot 0
  a_r6_rewind: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> (rptr == '0 && wptr == '0));
endmodule

// File: rtl/scsi_pio_regfile.sv
module scsi_pio_regfile
  import scsi_pio_pkg::*;
#(
  parameter int unsigned          DATA_W = 8,
  parameter logic [NUM_REGS-1:0]  RB_MASK = READBACK_MASK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [2*DATA_W-1:0] xfer_count,
  output logic [2:0]        target_id
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (RB_MASK[g]) begin : g_store
      always_ff @(posedge clk) begin
        if (rst)                          regs[g] <= '0;
        else if (wr && idx == IDX_W'(g))  regs[g] <= wdata;
      end
    end else begin : g_none
      assign regs[g] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            target_id <= '0;
    else if (wr && idx == IDX_TARGET)   target_id <= wdata[2:0];
  end

  assign rdata      = regs[idx];
  assign xfer_count = {regs[IDX_TC_HI], regs[IDX_TC_LO]};

  // R9: the target field follows the register-4 write
  a_r9_target: assert property (@(posedge clk) disable iff (rst)
    (wr && idx == IDX_TARGET) |=> (target_id == $past(wdata[2:0])));
endmodule

// File: rtl/scsi_pio_cmd.sv
module scsi_pio_cmd
  import scsi_pio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       dma_mode,
  output logic       strobe,
  output logic [6:0] code,
  output logic       xfer_load
);
  assign xfer_load = wr && !wdata[7] && (wdata[6:0] == CMD_XFER_INFO);

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_mode <= 1'b0;
      strobe   <= 1'b0;
      code     <= '0;
    end else begin
      strobe <= wr;
      if (wr) begin
        dma_mode <= wdata[7];
        code     <= wdata[6:0];
      end
    end
  end

  // R7: a command write yields a strobe, the code and the mode next cycle
  a_r7_dispatch: assert property (@(posedge clk) disable iff (rst)
    wr |=> (strobe && code == $past(wdata[6:0]) && dma_mode == $past(wdata[7])));

  // R7: the mode flag only moves on a command write
  a_r7_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(dma_mode) && !strobe));
endmodule

// File: rtl/scsi_pio_regif.sv
module scsi_pio_regif
  import scsi_pio_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [5:2]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              dma_mode,
  output logic              cmd_strobe,
  output logic [6:0]        cmd_code,
  output logic [2:0]        target_id
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [IDX_W-1:0]  idx;
  logic              rd_go;
  logic [DATA_W-1:0] rf_rdata, fifo_q, rd_reg;
  logic [CNT_W-1:0]  xfer_count;
  logic              xfer_load, rd_from_fifo;

  assign idx   = reg_addr;
  assign rd_go = reg_rd && !reg_wr;

  scsi_pio_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr         (reg_wr),
    .idx        (idx),
    .wdata      (reg_wdata),
    .rdata      (rf_rdata),
    .xfer_count (xfer_count),
    .target_id  (target_id)
  );

  scsi_pio_cmd u_cmd (
    .clk       (clk),
    .rst       (rst),
    .wr        (reg_wr && idx == IDX_CMD),
    .wdata     (reg_wdata[7:0]),
    .dma_mode  (dma_mode),
    .strobe    (cmd_strobe),
    .code      (cmd_code),
    .xfer_load (xfer_load)
  );

  scsi_pio_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .push       (reg_wr && idx == IDX_FIFO),
    .push_data  (reg_wdata),
    .pop_req    (rd_go && idx == IDX_FIFO),
    .load       (xfer_load),
    .load_count (xfer_count),
    .pop_data   (fifo_q),
    .pop_pulse  (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_reg       <= '0;
      rd_from_fifo <= 1'b0;
    end else if (rd_go) begin
      rd_from_fifo <= (idx == IDX_FIFO);
      if (idx != IDX_FIFO) rd_reg <= rf_rdata;
    end
  end

  assign reg_rdata = rd_from_fifo ? fifo_q : rd_reg;

  // R10: a read colliding with a write is dropped
  a_r10_rd_ignored: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_rd) |=> ($stable(reg_rdata) && !irq));

  // R1: with no read, the read data holds
  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/scsi_pio_regif_tb_top.sv
`timescale 1ns/1ps
module scsi_pio_regif_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:2] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq, dma_mode, cmd_strobe;
  logic [6:0] cmd_code;
  logic [2:0] target_id;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  scsi_pio_regif dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .dma_mode(dma_mode),
    .cmd_strobe(cmd_strobe), .cmd_code(cmd_code), .target_id(target_id)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic [7:0] sweep_val(input int i);
    return 8'(i * 29 + 11);
  endfunction

  function automatic logic [7:0] fill_val(input int i);
    return 8'(i * 7 + 3);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    check("R2 reset rdata", reg_rdata, 0);
    check("R7 reset dma_mode", dma_mode, 0);
    check("R9 reset target", target_id, 0);
    rd(4'd8);
    check("R2 reset reg8", reg_rdata, 0);

    // R1/R2 sweep: write every register except the FIFO port
    for (int i = 0; i < 16; i++) if (i != 2) wr(4'(i), sweep_val(i));
    for (int i = 0; i < 16; i++) begin
      if (i != 2) begin
        rd(4'(i));
        if (i == 0 || i == 1 || i == 3 || i == 8 || i >= 11)
          check($sformatf("R2 readback reg%0d", i), reg_rdata, sweep_val(i));
        else
          check($sformatf("R2 hidden reg%0d", i), reg_rdata, 0);
      end
    end
    check("R9 target from reg4", target_id, sweep_val(4) & 7);
    rd(4'd13);
    repeat (2) @(negedge clk);
    check("R1 rdata holds without read", reg_rdata, sweep_val(13));

    // R3/R4: fill to depth, one extra byte is dropped
    for (int i = 0; i < 64; i++) wr(4'd2, fill_val(i));
    wr(4'd2, 8'hEE);
    for (int i = 0; i < 64; i++) begin
      rd(4'd2);
      check($sformatf("R4 pop data %0d", i), reg_rdata, fill_val(i));
      check($sformatf("R4 irq pulse %0d", i), irq, 1);
      @(negedge clk);
      check("R4 irq one cycle", irq, 0);
    end
    // R5: empty read after the drop proves the 65th write never entered
    rd(4'd2);
    check("R3/R5 empty read data", reg_rdata, fill_val(63));
    check("R5 empty read irq", irq, 0);

    // R6: pointers rewind when drained, seen through a PIO reload
    wr(4'd2, 8'hA1); wr(4'd2, 8'hB2); wr(4'd2, 8'hC3);
    for (int i = 0; i < 3; i++) rd(4'd2);
    check("R4 order last", reg_rdata, 8'hC3);
    wr(4'd2, 8'hD4);
    wr(4'd0, 8'h02); wr(4'd1, 8'h00);
    wr(4'd3, 8'h10);
    check("R7 strobe", cmd_strobe, 1);
    check("R7 code", cmd_code, 8'h10);
    check("R7 pio mode", dma_mode, 0);
    @(negedge clk);
    check("R7 strobe one cycle", cmd_strobe, 0);
    rd(4'd2);
    check("R6 slot0 after rewind", reg_rdata, 8'hD4);
    check("R8 reload pop irq", irq, 1);
    rd(4'd2);
    check("R8 reload slot1", reg_rdata, 8'hB2);
    rd(4'd2);
    check("R8 reload count exhausted", irq, 0);

    // R8: the same code in DMA mode leaves the FIFO alone
    wr(4'd2, 8'h3C);
    wr(4'd3, 8'h90);
    check("R7 dma mode latched", dma_mode, 1);
    check("R7 dma code", cmd_code, 8'h10);
    rd(4'd2);
    check("R8 dma no reload data", reg_rdata, 8'h3C);
    check("R8 dma no reload irq", irq, 1);
    rd(4'd2);
    check("R8 dma count was one", irq, 0);
    rd(4'd3);
    check("R2 cmd readback", reg_rdata, 8'h90);
    wr(4'd9, 8'h55);
    check("R7 mode holds", dma_mode, 1);
    wr(4'd3, 8'h01);
    check("R7 pio again", dma_mode, 0);

    // R10: simultaneous write and read on the FIFO port
    rd(4'd0);
    @(negedge clk);
    reg_addr = 4'd2; reg_wdata = 8'h5A; reg_wr = 1'b1; reg_rd = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    check("R10 rdata unchanged", reg_rdata, 8'h02);
    check("R10 no pop irq", irq, 0);
    rd(4'd2);
    check("R10 write took effect", reg_rdata, 8'h5A);
    rd(4'd2);
    check("R10 single byte", irq, 0);

    // R9: another target value
    wr(4'd4, 8'hF2);
    check("R9 target update", target_id, 2);
    rd(4'd4);
    check("R2 reg4 hidden", reg_rdata, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule